// File: doc/BRIEF.md
# Coherent 16-bit Register Read Sequencer

This block returns a self-consistent 16-bit value from a register pair whose two bytes live at separate addresses and can change between two byte accesses. A counter that carries or borrows from its low byte into its high byte between the two reads would otherwise come back wrong by up to 256 counts. The sequencer sits above a byte-wide read engine and issues single-byte reads to it over a valid/ready request channel. Each read is answered by one response beat that carries a data byte and an error bit.

On a start strobe the block reads the high byte (first copy), then the low byte, then the high byte a second time. If the two high-byte copies agree, the first high byte and the low byte form the result. If they differ, a rollover happened during the read, so the low byte is fetched again and paired with the second high byte. A failed byte read ends the sequence at once with an error flag, and the last good result is kept.

Top module: `coh16_rd`

## Requirements
- R1: After reset, busy_o, done_o, err_o and req_valid_o are 0 and result_o is 0.
- R2: A start_i sampled while idle captures addr_hi_i and addr_lo_i. Byte requests then go out in the order high, low, high and, when a fourth read is needed, low.
- R3: Once req_valid_o is high it stays high, and req_addr_o holds its value, until the cycle in which req_ready_i is also high.
- R4: When the second high byte equals the first, exactly three requests are issued and result_o becomes {first high, low}.
- R5: When the second high byte differs from the first, a fourth request reads the low address again and result_o becomes {second high, second low}.
- R6: A response with rsp_err_i set ends the sequence. No further request is issued, done_o pulses with err_o high, and result_o keeps its previous value.
- R7: A start_i that arrives while busy_o is high has no effect on the addresses requested or on the running sequence.
- R8: busy_o rises the cycle after an accepted start and falls in the cycle in which done_o pulses. done_o lasts exactly one cycle, and err_o is high only while done_o is high.
- R9: At most one byte read is outstanding. No request is presented while a response is awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for a 16-bit read |
| addr_hi_i | input | ADDR_W | Address of the high byte |
| addr_lo_i | input | ADDR_W | Address of the low byte |
| busy_o | output | 1 | Sequence in progress |
| req_valid_o | output | 1 | Byte-read request valid |
| req_ready_i | input | 1 | Byte engine accepts the request |
| req_addr_o | output | ADDR_W | Byte address of the request |
| rsp_valid_i | input | 1 | Response beat valid |
| rsp_data_i | input | DATA_W | Byte returned |
| rsp_err_i | input | 1 | Byte read failed |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 1 | Sequence aborted by a byte error (with done_o) |
| result_o | output | 2*DATA_W | Last coherent 16-bit value |

## Verification
The bench sweeps high bytes at the wrap points 0x00, 0x7F and 0xFF, with and without a change between the two high reads. It places a byte error at every read position and varies the request-accept delay and the response latency. A design that always stops after three reads returns a value off by a full high-byte step whenever the high byte moved. A design that pairs the wrong bytes after a mismatch mixes the old high byte with the new low byte. A design that keeps going after an error, or that writes the result on an error, shows a request count or a result that does not match. Starts injected in the middle of a sequence catch a design that re-latches addresses or restarts while busy.

// File: rtl/coh16_pkg.sv
package coh16_pkg;
  typedef enum logic [1:0] {PH_H0, PH_L0, PH_H1, PH_L1} phase_e;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} state_e;
endpackage

// File: rtl/coh16_req_port.sv
module coh16_req_port #(
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              req_ready_i,
  output logic              req_valid_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic              accepted_o
);
  logic              valid_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      addr_q  <= load_addr_i;
    end else if (valid_q && req_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign req_valid_o = valid_q;
  assign req_addr_o  = addr_q;
  assign accepted_o  = valid_q && req_ready_i;

  a_r3_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o)));
  a_r9_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !req_valid_o);
endmodule

// File: rtl/coh16_byte_store.sv
module coh16_byte_store
  import coh16_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cap_i,
  input  phase_e              phase_i,
  input  logic [DATA_W-1:0]   data_i,
  input  logic                commit_i,
  input  logic                use_first_i,
  output logic                hi_match_o,
  output logic [2*DATA_W-1:0] result_o
);
  logic [DATA_W-1:0]   h0_q, l0_q, h1_q;
  logic [2*DATA_W-1:0] res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h0_q <= '0;
      l0_q <= '0;
      h1_q <= '0;
    end else if (cap_i) begin
      case (phase_i)
        PH_H0:   h0_q <= data_i;
        PH_L0:   l0_q <= data_i;
        PH_H1:   h1_q <= data_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       res_q <= '0;
    else if (commit_i) res_q <= use_first_i ? {h0_q, l0_q} : {h1_q, data_i};
  end

  assign hi_match_o = (data_i == h0_q);
  assign result_o   = res_q;
endmodule

// File: rtl/coh16_ctrl.sv
module coh16_ctrl
  import coh16_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_hi_i,
  input  logic [ADDR_W-1:0] addr_lo_i,
  input  logic              req_accept_i,
  input  logic              req_valid_i,
  input  logic              rsp_valid_i,
  input  logic              rsp_err_i,
  input  logic              hi_match_i,
  output logic              load_o,
  output logic [ADDR_W-1:0] load_addr_o,
  output logic              cap_o,
  output phase_e            phase_o,
  output logic              commit_o,
  output logic              use_first_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  state_e            state_q, state_d;
  phase_e            phase_q, phase_d;
  logic [ADDR_W-1:0] hi_q, lo_q;
  logic              fin, fail, done_q, err_q;

  always_comb begin
    state_d     = state_q;
    phase_d     = phase_q;
    load_o      = 1'b0;
    load_addr_o = hi_q;
    cap_o       = 1'b0;
    commit_o    = 1'b0;
    use_first_o = 1'b0;
    fin         = 1'b0;
    fail        = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        load_o      = 1'b1;
        load_addr_o = addr_hi_i;
        phase_d     = PH_H0;
        state_d     = ST_REQ;
      end
      ST_REQ: if (req_accept_i) state_d = ST_WAIT;
      ST_WAIT: if (rsp_valid_i) begin
        if (rsp_err_i) begin
          fail    = 1'b1;
          state_d = ST_IDLE;
        end else begin
          cap_o = 1'b1;
          case (phase_q)
            PH_H0: begin
              phase_d = PH_L0; load_o = 1'b1; load_addr_o = lo_q; state_d = ST_REQ;
            end
            PH_L0: begin
              phase_d = PH_H1; load_o = 1'b1; load_addr_o = hi_q; state_d = ST_REQ;
            end
            PH_H1: begin
              if (hi_match_i) begin
                commit_o = 1'b1; use_first_o = 1'b1; fin = 1'b1; state_d = ST_IDLE;
              end else begin
                phase_d = PH_L1; load_o = 1'b1; load_addr_o = lo_q; state_d = ST_REQ;
              end
            end
            default: begin
              commit_o = 1'b1; fin = 1'b1; state_d = ST_IDLE;
            end
          endcase
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= PH_H0;
      hi_q    <= '0;
      lo_q    <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      done_q  <= fin || fail;
      err_q   <= fail;
      if (state_q == ST_IDLE && start_i) begin
        hi_q <= addr_hi_i;
        lo_q <= addr_lo_i;
      end
    end
  end

  assign phase_o = phase_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign err_o   = err_q;

  a_r9_single_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |-> !req_valid_i);
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
endmodule

// File: rtl/coh16_rd.sv
module coh16_rd
  import coh16_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  localparam int RES_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_hi_i,
  input  logic [ADDR_W-1:0] addr_lo_i,
  output logic              busy_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o,
  input  logic              rsp_valid_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  input  logic              rsp_err_i,
  output logic              done_o,
  output logic              err_o,
  output logic [RES_W-1:0]  result_o
);
  logic              load, cap, commit, use_first, hi_match, accepted;
  logic [ADDR_W-1:0] load_addr;
  phase_e            phase;

  coh16_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .addr_hi_i, .addr_lo_i,
    .req_accept_i(accepted), .req_valid_i(req_valid_o),
    .rsp_valid_i, .rsp_err_i, .hi_match_i(hi_match),
    .load_o(load), .load_addr_o(load_addr), .cap_o(cap), .phase_o(phase),
    .commit_o(commit), .use_first_o(use_first),
    .busy_o, .done_o, .err_o
  );

  coh16_req_port #(.ADDR_W(ADDR_W)) u_port (
    .clk_i, .rst_ni, .load_i(load), .load_addr_i(load_addr),
    .req_ready_i, .req_valid_o, .req_addr_o, .accepted_o(accepted)
  );

  coh16_byte_store #(.DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni, .cap_i(cap), .phase_i(phase), .data_i(rsp_data_i),
    .commit_i(commit), .use_first_i(use_first),
    .hi_match_o(hi_match), .result_o
  );

  a_r6_result_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> $stable(result_o));
  a_r8_busy_off_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: tb/coh16_rd_test.sv
module coh16_rd_test;
  localparam int AW = 7;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] a_hi = '0, a_lo = '0;
  logic          busy, rq_v, rq_r = 1'b0, rs_v = 1'b0, rs_e = 1'b0, done, err;
  logic [AW-1:0] rq_a;
  logic [DW-1:0] rs_d = '0;
  logic [2*DW-1:0] res;

  int n_run = 0, n_fail = 0;
  logic [2*DW-1:0] prev_res = '0;

  always #4 clk = ~clk;

  coh16_rd #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_hi_i(a_hi), .addr_lo_i(a_lo),
    .busy_o(busy), .req_valid_o(rq_v), .req_ready_i(rq_r), .req_addr_o(rq_a),
    .rsp_valid_i(rs_v), .rsp_data_i(rs_d), .rsp_err_i(rs_e),
    .done_o(done), .err_o(err), .result_o(res)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic run_seq(input logic [AW-1:0] ah, input logic [AW-1:0] al,
                         input logic [DW-1:0] h0, input logic [DW-1:0] l0,
                         input logic [DW-1:0] h1, input logic [DW-1:0] l1,
                         input int err_at, input int rdy_dly, input int lat,
                         input bit inject);
    logic [DW-1:0] scr [4];
    logic [AW-1:0] seen [8];
    int nreq = 0, nrsp = 0, wcnt = 0, cnt = 0, cyc = 0, need, exp_req;
    bit pend = 0, busy_bad = 0, err_bad = 0, got_done = 0;
    logic [2*DW-1:0] exp_res;
    bit exp_err;
    scr[0] = h0; scr[1] = l0; scr[2] = h1; scr[3] = l1;
    need = (h1 == h0) ? 3 : 4;
    if (err_at < need) begin
      exp_req = err_at + 1; exp_err = 1'b1; exp_res = prev_res;
    end else begin
      exp_req = need; exp_err = 1'b0;
      exp_res = (h1 == h0) ? {h0, l0} : {h1, l1};
    end
    @(negedge clk);
    start = 1'b1; a_hi = ah; a_lo = al;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R8 busy after start", busy, 1);
    while (cyc < 200) begin
      cyc++;
      if (done) begin got_done = 1; break; end
      if (busy !== 1'b1) busy_bad = 1;
      if (err !== 1'b0) err_bad = 1;
      rq_r = 1'b0; rs_v = 1'b0; rs_e = 1'b0; start = 1'b0;
      if (inject && cyc == 3) begin
        start = 1'b1; a_hi = ~ah; a_lo = ~al;
      end
      if (pend) begin
        if (cnt == 0) begin
          rs_v = 1'b1; rs_d = scr[nrsp % 4]; rs_e = (nrsp == err_at); pend = 0; nrsp++;
        end else cnt--;
      end else if (rq_v) begin
        if (wcnt >= rdy_dly) begin
          rq_r = 1'b1; if (nreq < 8) seen[nreq] = rq_a; nreq++; pend = 1; cnt = lat; wcnt = 0;
        end else wcnt++;
      end
      @(negedge clk);
    end
    rq_r = 1'b0; rs_v = 1'b0; rs_e = 1'b0; start = 1'b0;
    chk(got_done, "R8 done reached", got_done, 1);
    chk(!busy_bad && busy === 1'b0, "R8 busy window", busy, 0);
    chk(!err_bad, "R8 err only with done", err_bad, 0);
    chk(nreq == exp_req, exp_err ? "R6 requests before abort" :
        (need == 3 ? "R4 three reads" : "R5 four reads"), nreq, exp_req);
    for (int k = 0; k < nreq && k < 8; k++)
      chk(seen[k] == ((k % 2 == 0) ? ah : al), inject ? "R7 address kept" : "R2 request order",
          seen[k], (k % 2 == 0) ? ah : al);
    chk(err === exp_err, "R6 err flag", err, exp_err);
    chk(res === exp_res, exp_err ? "R6 result kept" : (need == 3 ? "R4 result" : "R5 result"),
        res, exp_res);
    prev_res = exp_res;
    @(negedge clk);
    chk(done === 1'b0 && err === 1'b0, "R8 done single cycle", done, 0);
    chk(busy === 1'b0 && rq_v === 1'b0, "R7 idle after sequence", busy, 0);
  endtask

  initial begin
    logic [DW-1:0] hv [3];
    hv[0] = 8'h00; hv[1] = 8'h7F; hv[2] = 8'hFF;
    repeat (3) @(negedge clk);
    chk(busy === 0 && done === 0 && err === 0 && rq_v === 0, "R1 reset outputs", busy, 0);
    chk(res === '0, "R1 reset result", res, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int t = 0; t < 3; t++)
      for (int hi = 0; hi < 3; hi++)
        for (int d = 0; d < 2; d++)
          for (int e = 0; e < 5; e++) begin
            logic [DW-1:0] h0v, h1v, l0v;
            h0v = hv[hi];
            h1v = h0v + DW'(d);
            l0v = h0v ^ 8'h5A;
            run_seq(AW'(7'h10 + hi + 3 * e), AW'(7'h55 ^ (hi + 4 * d)),
                    h0v, l0v, h1v, ~l0v, e, t, (t + e) % 3, (e % 2) == 1);
          end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule